// File: doc/BRIEF.md
# GPIO Expander Register Core

This core controls an 8-pin bidirectional general-purpose I/O port through a small synchronous register bus. A host writes output levels, pin directions, pull enables, interrupt masks and per-pin edge selections. It reads back the live pin levels and the edge flags that have been captured. Pin inputs pass through a synchroniser. Each pin has its own edge detector, and the resulting events are held in sticky flags. Software clears a flag by writing a one to it, and the hardware also clears it when the pin's edge selection is rewritten to a different value. An active-low interrupt line stays asserted while any unmasked pin holds a pending flag.

A small lookup mode lets one of the low pins follow a truth table instead of the data register. The table is indexed by the synchronised levels of the pins below that pin. In one setting pin 2 follows a 4-entry table indexed by pins 1:0. In the other setting pin 3 follows an 8-entry table indexed by pins 2:0. The pull settings are exported only as control bits for the pad ring.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset the direction (0x01) and interrupt mask (0x05) registers read 0xFF. Pull-up (0x02), pull-down (0x03), both sense registers (0x06, 0x07) and the lookup mode (0x10) read 0x00. `pin_oe` is 0 and `irq_n` is 1.
- R2: A pin drives when its direction bit is 0 (`pin_oe` bit = 1) and is an input when the bit is 1. A write to 0x00 sets the levels on `pin_out`.
- R3: A read of 0x00 returns the pin levels after a two-flop synchroniser, whatever the direction setting. A change at `pin_in` is visible after the second rising clock edge.
- R4: Each pin has a 2-bit sense field: 00 none, 01 rising, 10 falling, 11 both edges. Pins 7:4 sit in 0x06 and pins 3:0 sit in 0x07. Pin k uses bits 2*(k mod 4)+1 : 2*(k mod 4) of its register.
- R5: An edge matching a pin's sense field sets that pin's bit in the event register (0x09). The bit stays set until it is cleared.
- R6: A pin's bit in the interrupt source register (0x08) sets on a matching edge only while its mask bit in 0x05 is 0. `irq_n` is low while any source bit is set.
- R7: Writing 1 to a bit of 0x09 clears that event bit and the matching source bit. Writing 0 leaves both unchanged.
- R8: A write to 0x06 or 0x07 that changes a pin's sense field clears that pin's event and source bits. Pins whose field is unchanged keep their bits.
- R9: When a matching edge and a clear land in the same cycle, the flag ends up set.
- R10: The lookup mode field is bits 1:0 of 0x10. In mode 01, pin 2 outputs bit n of table 0x11 (bits 3:0), with n = pins 1:0. In mode 10, pin 3 outputs bit n of table 0x13 (bits 7:0), with n = pins 2:0. Modes 00 and 11 leave every pin on the data register.
- R11: These bits always read 0: unused bits of 0x10 and 0x11, and registers 0x04, 0x12, 0x14, 0x15 and 0xAB.
- R12: Registers 0x02 and 0x03 appear bit for bit on `pull_up_en` and `pull_dn_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Register address for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Levels seen at the pads |
| pin_out | output | NPINS | Levels to drive on the pads |
| pin_oe | output | NPINS | Per-pin drive enable, 1 = drive |
| pull_up_en | output | NPINS | Pull-up enable per pin |
| pull_dn_en | output | NPINS | Pull-down enable per pin |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The edge detectors are driven with a rising step across five pins that have mixed sense codes. This separates the rising, falling, both and none encodings, and it confirms that the high sense register reaches pin 4. A falling step follows, which shows that the falling and both codes respond while rising-only pins stay quiet. The lookup mode is walked over every index of both tables using asymmetric table patterns, so a swapped index bit or a wrong table shows up. A mode-3 pass checks that the unused code falls back to the data register. A clear and an edge are aligned in the same cycle to check set-over-clear priority. A sense rewrite that changes one field and keeps another shows that the automatic clear applies per pin.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   localparam logic [7:0] A_DATA     = 8'h00;
   localparam logic [7:0] A_DIR      = 8'h01;
   localparam logic [7:0] A_PULLUP   = 8'h02;
   localparam logic [7:0] A_PULLDN   = 8'h03;
   localparam logic [7:0] A_RSVD     = 8'h04;
   localparam logic [7:0] A_MASK     = 8'h05;
   localparam logic [7:0] A_SENSE_HI = 8'h06;
   localparam logic [7:0] A_SENSE_LO = 8'h07;
   localparam logic [7:0] A_SRC      = 8'h08;
   localparam logic [7:0] A_EVT      = 8'h09;
   localparam logic [7:0] A_LUTMODE  = 8'h10;
   localparam logic [7:0] A_TBL_A    = 8'h11;
   localparam logic [7:0] A_TBL_B    = 8'h13;

   typedef enum logic [1:0] {
      SENSE_NONE = 2'b00,
      SENSE_RISE = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   typedef enum logic [1:0] {
      LUT_OFF  = 2'b00,
      LUT_2TO1 = 2'b01,
      LUT_3TO1 = 2'b10,
      LUT_RSVD = 2'b11
   } lut_mode_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpx_event_bank.sv
module gpx_event_bank
   import gpx_pkg::*;
#(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   lvl,
   input  logic [2*W-1:0] sense,
   input  logic [W-1:0]   mask,
   input  logic [W-1:0]   clr,
   output logic [W-1:0]   evt,
   output logic [W-1:0]   src
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         logic prev_q;
         logic evt_q;
         logic src_q;
         logic hit;

         always_comb begin
            hit = 1'b0;
            case (sense_e'(sense[2*i +: 2]))
               SENSE_RISE: hit = lvl[i] & ~prev_q;
               SENSE_FALL: hit = ~lvl[i] & prev_q;
               SENSE_BOTH: hit = lvl[i] ^ prev_q;
               default:    hit = 1'b0;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               evt_q  <= 1'b0;
               src_q  <= 1'b0;
            end else begin
               prev_q <= lvl[i];
               if (hit)         evt_q <= 1'b1;
               else if (clr[i]) evt_q <= 1'b0;
               if (hit && !mask[i]) src_q <= 1'b1;
               else if (clr[i])     src_q <= 1'b0;
            end
         end

         assign evt[i] = evt_q;
         assign src[i] = src_q;
      end
   endgenerate

endmodule

// File: rtl/gpx_out_mux.sv
module gpx_out_mux
   import gpx_pkg::*;
#(
   parameter int W     = 8,
   parameter int SEL_W = 3,
   localparam int TA_W = 2 ** (SEL_W - 1),
   localparam int TB_W = 2 ** SEL_W
) (
   input  lut_mode_e        mode,
   input  logic [SEL_W-1:0] sel,
   input  logic [W-1:0]     drv,
   input  logic [TA_W-1:0]  tbl_a,
   input  logic [TB_W-1:0]  tbl_b,
   output logic [W-1:0]     pin_out
);

   generate
      if (W <= SEL_W) begin : g_bad_width
         $error("gpx_out_mux: port narrower than lookup index");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == SEL_W - 1) begin : g_lut_a
            assign pin_out[i] = (mode == LUT_2TO1) ? tbl_a[sel[SEL_W-2:0]] : drv[i];
         end else if (i == SEL_W) begin : g_lut_b
            assign pin_out[i] = (mode == LUT_3TO1) ? tbl_b[sel] : drv[i];
         end else begin : g_plain
            assign pin_out[i] = drv[i];
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
   import gpx_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pull_up_en,
   output logic [NPINS-1:0]  pull_dn_en,
   output logic              irq_n
);

   localparam int SENSE_W = 2 * NPINS;
   localparam int SEL_W   = 3;
   localparam int TA_W    = 2 ** (SEL_W - 1);
   localparam int TB_W    = 2 ** SEL_W;

   generate
      if (NPINS != 8 || DATA_W != 8) begin : g_bad_width
         $error("gpio_expander_core: register map needs NPINS = DATA_W = 8");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("gpio_expander_core: ADDR_W must be at least 8");
      end
   endgenerate

   logic [NPINS-1:0]   data_q, dir_q, pu_q, pd_q, mask_q;
   logic [SENSE_W-1:0] sense_q, sense_nxt;
   lut_mode_e          mode_q;
   logic [TA_W-1:0]    tbl_a_q;
   logic [TB_W-1:0]    tbl_b_q;
   logic [NPINS-1:0]   pin_lvl, evt_w, src_w, sense_chg, evt_clr;

   function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] target);
      return a == ADDR_W'(target);
   endfunction

   // sense registers: next value and per-pin change detection
   always_comb begin
      sense_nxt = sense_q;
      if (bus_we && at(bus_addr, A_SENSE_HI)) sense_nxt[SENSE_W-1 -: DATA_W] = bus_wdata;
      if (bus_we && at(bus_addr, A_SENSE_LO)) sense_nxt[DATA_W-1:0]          = bus_wdata;
   end

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_chg
         assign sense_chg[i] = |(sense_nxt[2*i +: 2] ^ sense_q[2*i +: 2]);
      end
   endgenerate

   assign evt_clr = ((bus_we && at(bus_addr, A_EVT)) ? bus_wdata : '0) | sense_chg;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '1;
         dir_q   <= '1;
         pu_q    <= '0;
         pd_q    <= '0;
         mask_q  <= '1;
         sense_q <= '0;
         mode_q  <= LUT_OFF;
         tbl_a_q <= '0;
         tbl_b_q <= '0;
      end else begin
         sense_q <= sense_nxt;
         if (bus_we) begin
            if (at(bus_addr, A_DATA))    data_q  <= bus_wdata;
            if (at(bus_addr, A_DIR))     dir_q   <= bus_wdata;
            if (at(bus_addr, A_PULLUP))  pu_q    <= bus_wdata;
            if (at(bus_addr, A_PULLDN))  pd_q    <= bus_wdata;
            if (at(bus_addr, A_MASK))    mask_q  <= bus_wdata;
            if (at(bus_addr, A_LUTMODE)) mode_q  <= lut_mode_e'(bus_wdata[1:0]);
            if (at(bus_addr, A_TBL_A))   tbl_a_q <= bus_wdata[TA_W-1:0];
            if (at(bus_addr, A_TBL_B))   tbl_b_q <= bus_wdata[TB_W-1:0];
         end
      end
   end

   gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_lvl)
   );

   gpx_event_bank #(.W(NPINS)) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pin_lvl),
      .sense(sense_q),
      .mask (mask_q),
      .clr  (evt_clr),
      .evt  (evt_w),
      .src  (src_w)
   );

   gpx_out_mux #(.W(NPINS), .SEL_W(SEL_W)) u_mux (
      .mode   (mode_q),
      .sel    (pin_lvl[SEL_W-1:0]),
      .drv    (data_q),
      .tbl_a  (tbl_a_q),
      .tbl_b  (tbl_b_q),
      .pin_out(pin_out)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (at(bus_addr, A_DATA))     bus_rdata = pin_lvl;
      if (at(bus_addr, A_DIR))      bus_rdata = dir_q;
      if (at(bus_addr, A_PULLUP))   bus_rdata = pu_q;
      if (at(bus_addr, A_PULLDN))   bus_rdata = pd_q;
      if (at(bus_addr, A_MASK))     bus_rdata = mask_q;
      if (at(bus_addr, A_SENSE_HI)) bus_rdata = sense_q[SENSE_W-1 -: DATA_W];
      if (at(bus_addr, A_SENSE_LO)) bus_rdata = sense_q[DATA_W-1:0];
      if (at(bus_addr, A_SRC))      bus_rdata = src_w;
      if (at(bus_addr, A_EVT))      bus_rdata = evt_w;
      if (at(bus_addr, A_LUTMODE))  bus_rdata = DATA_W'(mode_q);
      if (at(bus_addr, A_TBL_A))    bus_rdata = DATA_W'(tbl_a_q);
      if (at(bus_addr, A_TBL_B))    bus_rdata = tbl_b_q;
   end

   assign pin_oe     = ~dir_q;
   assign pull_up_en = pu_q;
   assign pull_dn_en = pd_q;
   assign irq_n      = ~|src_w;

endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  evt,
   input logic [NPINS-1:0]  src,
   input logic [NPINS-1:0]  mask,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq_n
);

   assert_src_has_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src & ~evt) == '0);

   assert_masked_no_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((src & ~$past(src) & $past(mask)) == '0));

   assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(bus_we));

   assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(8'h01)) |=> $stable(pin_oe));

   assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8'h04)) |-> (bus_rdata == '0));

endmodule

bind gpio_expander_core gpx_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .evt      (evt_w),
   .src      (src_w),
   .mask     (mask_q),
   .pin_oe   (pin_oe),
   .irq_n    (irq_n)
);

// File: tb/test_gpio_expander_core.sv
`timescale 1ns/1ps
module test_gpio_expander_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out, pin_oe, pull_up_en, pull_dn_en;
   logic       irq_n;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gpio_expander_core i_gpio_expander_core (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_en(pull_up_en),
      .pull_dn_en(pull_dn_en), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(8'h01, d); chk("R1 direction reset", d, 8'hFF);
      rd(8'h05, d); chk("R1 mask reset", d, 8'hFF);
      rd(8'h02, d); chk("R1 pull-up reset", d, 8'h00);
      rd(8'h03, d); chk("R1 pull-down reset", d, 8'h00);
      rd(8'h06, d); chk("R1 sense high reset", d, 8'h00);
      rd(8'h07, d); chk("R1 sense low reset", d, 8'h00);
      rd(8'h10, d); chk("R1 lookup mode reset", d, 8'h00);
      chk("R1 pin_oe reset", pin_oe, 8'h00);
      chk("R1 irq_n reset", irq_n, 1'b1);
   endtask

   task automatic t_data_out;
      wr(8'h01, 8'hF0);
      wr(8'h00, 8'hA5);
      chk("R2 output enable from direction", pin_oe, 8'h0F);
      chk("R2 driven levels", pin_out & pin_oe, 8'h05);
   endtask

   task automatic t_data_read;
      @(negedge clk);
      pin_in = 8'h3C; bus_addr = 8'h00;
      @(negedge clk);
      #0.5; chk("R3 one edge after change still old", bus_rdata, 8'h00);
      @(negedge clk);
      #0.5; chk("R3 two edges after change visible", bus_rdata, 8'h3C);
      set_pins(8'h00);
   endtask

   task automatic t_sense_edges;
      logic [7:0] d;
      wr(8'h07, 8'h39);   // pin0 rise, pin1 fall, pin2 both, pin3 none
      wr(8'h06, 8'h01);   // pin4 rise
      set_pins(8'h1F);
      rd(8'h09, d); chk("R4 R5 rising step events", d, 8'h15);
      wr(8'h09, 8'hFF);
      rd(8'h09, d); chk("R7 clear all events", d, 8'h00);
      set_pins(8'h00);
      rd(8'h09, d); chk("R4 R5 falling step events", d, 8'h06);
      rd(8'h08, d); chk("R6 masked pins give no source", d, 8'h00);
      chk("R6 irq idle while masked", irq_n, 1'b1);
   endtask

   task automatic t_mask_irq;
      logic [7:0] d;
      wr(8'h07, 8'h01);
      wr(8'h06, 8'h00);
      wr(8'h09, 8'hFF);
      wr(8'h05, 8'hFE);
      set_pins(8'h01);
      rd(8'h08, d); chk("R6 unmasked source set", d, 8'h01);
      chk("R6 irq asserted", irq_n, 1'b0);
      wr(8'h09, 8'h00);
      rd(8'h09, d); chk("R7 zero write keeps event", d, 8'h01);
      chk("R7 zero write keeps irq", irq_n, 1'b0);
      wr(8'h09, 8'h01);
      rd(8'h09, d); chk("R7 one write clears event", d, 8'h00);
      rd(8'h08, d); chk("R7 one write clears source", d, 8'h00);
      chk("R7 irq released", irq_n, 1'b1);
   endtask

   task automatic t_sense_change;
      logic [7:0] d;
      set_pins(8'h00);
      wr(8'h07, 8'h31);   // pin0 rise, pin2 both
      set_pins(8'h05);
      rd(8'h09, d); chk("R5 two pin events", d, 8'h05);
      wr(8'h07, 8'h11);   // pin2 field changes, pin0 kept
      rd(8'h09, d); chk("R8 changed field clears only its pin", d, 8'h01);
      rd(8'h08, d); chk("R8 unchanged pin keeps source", d, 8'h01);
      wr(8'h07, 8'h11);
      rd(8'h09, d); chk("R8 identical rewrite keeps event", d, 8'h01);
      wr(8'h07, 8'h10);   // pin0 field changes
      rd(8'h09, d); chk("R8 pin0 field change clears event", d, 8'h00);
      chk("R8 pin0 field change releases irq", irq_n, 1'b1);
   endtask

   task automatic t_set_beats_clear;
      logic [7:0] d;
      wr(8'h07, 8'h01);
      set_pins(8'h00);
      set_pins(8'h01);
      set_pins(8'h00);
      rd(8'h09, d); chk("R9 setup event present", d, 8'h01);
      @(negedge clk); pin_in = 8'h01;
      @(negedge clk);
      @(negedge clk); bus_we = 1'b1; bus_addr = 8'h09; bus_wdata = 8'h01;
      @(negedge clk); bus_we = 1'b0;
      rd(8'h09, d); chk("R9 set wins over clear event", d, 8'h01);
      rd(8'h08, d); chk("R9 set wins over clear source", d, 8'h01);
      wr(8'h09, 8'h01);
      rd(8'h09, d); chk("R9 later clear alone works", d, 8'h00);
   endtask

   task automatic t_lookup;
      logic [7:0] d;
      wr(8'h01, 8'h00);
      wr(8'h00, 8'h00);
      wr(8'h11, 8'hF6);
      rd(8'h11, d); chk("R11 table A upper bits read zero", d, 8'h06);
      wr(8'h10, 8'h01);
      for (int n = 0; n < 4; n++) begin
         set_pins(8'(n));
         chk($sformatf("R10 2-to-1 index %0d", n), pin_out[2], 1'((8'h06 >> n) & 1));
      end
      wr(8'h13, 8'h96);
      wr(8'h10, 8'h02);
      for (int n = 0; n < 8; n++) begin
         set_pins(8'(n));
         chk($sformatf("R10 3-to-1 index %0d", n), pin_out[3], 1'((8'h96 >> n) & 1));
         chk($sformatf("R10 3-to-1 pin2 from data %0d", n), pin_out[2], 1'b0);
      end
      wr(8'h10, 8'hFF);
      rd(8'h10, d); chk("R11 mode upper bits read zero", d, 8'h03);
      wr(8'h00, 8'h0C);
      set_pins(8'h00);
      chk("R10 mode 11 uses data register", pin_out[3:2], 2'b11);
      wr(8'h04, 8'hFF); rd(8'h04, d); chk("R11 reserved 0x04", d, 8'h00);
      wr(8'h12, 8'hFF); rd(8'h12, d); chk("R11 reserved 0x12", d, 8'h00);
      wr(8'hAB, 8'hFF); rd(8'hAB, d); chk("R11 reserved 0xAB", d, 8'h00);
   endtask

   task automatic t_pull;
      logic [7:0] d;
      wr(8'h02, 8'h81);
      wr(8'h03, 8'h42);
      chk("R12 pull-up export", pull_up_en, 8'h81);
      chk("R12 pull-down export", pull_dn_en, 8'h42);
      rd(8'h02, d); chk("R12 pull-up readback", d, 8'h81);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_data_out();
      t_data_read();
      t_sense_edges();
      t_mask_irq();
      t_sense_change();
      t_set_beats_clear();
      t_lookup();
      t_pull();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule